// File: doc/BRIEF.md
# Register Width Extension and Leading-Bit Count Unit

This combinational unit applies one of six single-operand bit manipulations to a 32-bit register value. Four of them reshape the operand in place: the low byte or low halfword is either sign-extended to the full word or kept while every higher bit is cleared. The other two count how many identical bits lead the word from its most significant end, counting zeros or counting ones. It sits beside an execute stage. Decoding supplies a 3-bit operation code and the source value, and the register file consumes the result.

Besides the result, the unit reports where the result is written and which status flags change. The reshape operations return their result to the operand's own register and update both the zero and sign flags. The count operations always send their result to the fixed register R0 and touch only the zero flag. The two unused operation codes produce no write of any kind.

Top module: `xlc_unit`

## Requirements
- R1: Code 0 returns bits 7:0 of the operand with bit 7 copied into bits 31:8.
- R2: Code 1 returns bits 15:0 of the operand with bit 15 copied into bits 31:16.
- R3: Code 2 returns the operand ANDed with 0x000000FF.
- R4: Code 3 returns the operand ANDed with 0x0000FFFF.
- R5: Code 4 returns, zero-extended to 32 bits, the number of consecutive zero bits counted down from bit 31; an all-zero operand gives 32.
- R6: Code 5 returns the number of consecutive one bits counted down from bit 31; an all-ones operand gives 32.
- R7: For codes 0 to 5 `res_we` is 1. `dst_r0` is 1 for codes 4 and 5, which write R0, and 0 for codes 0 to 3, which write the operand register.
- R8: For codes 0 to 3 both flag enables are 1, `flag_z` is 1 exactly when the result is zero, and `flag_s` equals result bit 31.
- R9: For codes 4 and 5 `flag_z_we` is 1 and `flag_s_we` is 0, and `flag_z` is 1 exactly when the count is zero.
- R10: Codes 6 and 7 drive `res_we`, `dst_r0`, `flag_z_we` and `flag_s_we` to 0 and drive the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code, 0 to 5 valid, 6 and 7 unused |
| operand | input | 32 | Source register value |
| result | output | 32 | Reshaped value or leading count |
| res_we | output | 1 | Result is to be written |
| dst_r0 | output | 1 | 1: write R0; 0: write the operand register |
| flag_z | output | 1 | Zero flag value |
| flag_s | output | 1 | Sign flag value |
| flag_z_we | output | 1 | Zero flag write enable |
| flag_s_we | output | 1 | Sign flag write enable |

## Verification
Two decisions that share one evaluation deserve the closest look. The first pair is steering to R0 and raising the zero flag: when the operand's top bit already differs from the counted value, the count is zero, so the unit writes 0 to R0, sets Z and must leave S alone. The second pair is Z and S from a reshape operation: an operand of 0x80 under code 0, for example, must set S and clear Z together. Directed operands that sit on these edges, plus a long pseudo-random run, are applied one per clock. Every output is compared with a behavioural model that rebuilds each result with integer arithmetic and loops.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  typedef enum logic [2:0] {
    XOP_SXB = 3'd0,
    XOP_SXH = 3'd1,
    XOP_ZXB = 3'd2,
    XOP_ZXH = 3'd3,
    XOP_CLZ = 3'd4,
    XOP_CLO = 3'd5,
    XOP_RS6 = 3'd6,
    XOP_RS7 = 3'd7
  } xop_e;

  localparam int XLC_DATA_W = 32;
  localparam int XLC_BYTE_W = 8;
  localparam int XLC_HALF_W = 16;
endpackage

// File: rtl/xlc_extend.sv
module xlc_extend #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic              pick_half,
  input  logic              keep_sign,
  output logic [DATA_W-1:0] ext_out
);
  localparam int N_LANE = 2;

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v,
                                              input int w, input logic sgn);
    logic [DATA_W-1:0] o;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < w) o[i] = v[i];
      else       o[i] = sgn & v[w-1];
    end
    return o;
  endfunction

  logic [DATA_W-1:0] lane_out [N_LANE];

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    localparam int LW = (k == 0) ? BYTE_W : HALF_W;
    assign lane_out[k] = widen(src, LW, keep_sign);
  end

  assign ext_out = pick_half ? lane_out[1] : lane_out[0];
endmodule

// File: rtl/xlc_leadcnt.sv
module xlc_leadcnt #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] src,
  input  logic              count_ones,
  output logic [CNT_W-1:0]  cnt
);
  function automatic logic [CNT_W-1:0] lead_zeros(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] n;
    logic             hit;
    n   = '0;
    hit = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction

  logic [DATA_W-1:0] scan_word;
  assign scan_word = count_ones ? ~src : src;
  assign cnt       = lead_zeros(scan_word);
endmodule

// File: rtl/xlc_flags.sv
module xlc_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              upd_zs,
  input  logic              upd_z_only,
  output logic              z,
  output logic              s,
  output logic              z_we,
  output logic              s_we
);
  assign z    = (res == '0);
  assign s    = res[DATA_W-1];
  assign z_we = upd_zs | upd_z_only;
  assign s_we = upd_zs;
endmodule

// File: rtl/xlc_unit.sv
module xlc_unit
  import xlc_pkg::*;
#(
  parameter int DATA_W = XLC_DATA_W,
  parameter int BYTE_W = XLC_BYTE_W,
  parameter int HALF_W = XLC_HALF_W
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              res_we,
  output logic              dst_r0,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_z_we,
  output logic              flag_s_we
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  xop_e              op;
  logic              is_ext_op;
  logic              is_cnt_op;
  logic [DATA_W-1:0] ext_val;
  logic [CNT_W-1:0]  lead_cnt;

  assign op        = xop_e'(op_sel);
  assign is_ext_op = (op == XOP_SXB) || (op == XOP_SXH) ||
                     (op == XOP_ZXB) || (op == XOP_ZXH);
  assign is_cnt_op = (op == XOP_CLZ) || (op == XOP_CLO);

  xlc_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_ext (
    .src       (operand),
    .pick_half ((op == XOP_SXH) || (op == XOP_ZXH)),
    .keep_sign ((op == XOP_SXB) || (op == XOP_SXH)),
    .ext_out   (ext_val)
  );

  xlc_leadcnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .src        (operand),
    .count_ones (op == XOP_CLO),
    .cnt        (lead_cnt)
  );

  always_comb begin
    if (is_cnt_op)      result = {{(DATA_W-CNT_W){1'b0}}, lead_cnt};
    else if (is_ext_op) result = ext_val;
    else                result = '0;
  end

  assign res_we = is_ext_op | is_cnt_op;
  assign dst_r0 = is_cnt_op;

  xlc_flags #(.DATA_W(DATA_W)) u_flg (
    .res        (result),
    .upd_zs     (is_ext_op),
    .upd_z_only (is_cnt_op),
    .z          (flag_z),
    .s          (flag_s),
    .z_we       (flag_z_we),
    .s_we       (flag_s_we)
  );
endmodule

// File: rtl/xlc_unit_chk.sv
module xlc_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] result,
  input logic              res_we,
  input logic              dst_r0,
  input logic              flag_s,
  input logic              flag_z_we,
  input logic              flag_s_we
);
  always_comb begin
    if (!$isunknown({op_sel, operand})) begin
      a_r7_count_to_r0: assert (!(op_sel == 3'd4 || op_sel == 3'd5) || (dst_r0 && res_we))
        else $error("count op not steered to R0");
      a_r9_count_no_sign: assert (!dst_r0 || (flag_z_we && !flag_s_we))
        else $error("count op flag enables wrong");
      a_r8_sign_is_msb: assert (!flag_s_we || (flag_s == result[DATA_W-1]))
        else $error("sign flag differs from result msb");
      a_r5_count_range: assert (!dst_r0 || (result <= DATA_W))
        else $error("leading count out of range");
      a_r10_reserved_quiet: assert (op_sel < 3'd6 || !(res_we || flag_z_we || flag_s_we || dst_r0))
        else $error("unused code produced a write");
      a_r1_low_byte_kept: assert (!(res_we && !dst_r0) || (result[7:0] == operand[7:0]))
        else $error("low byte altered by reshape op");
    end
  end
endmodule

bind xlc_unit xlc_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .op_sel    (op_sel),
  .operand   (operand),
  .result    (result),
  .res_we    (res_we),
  .dst_r0    (dst_r0),
  .flag_s    (flag_s),
  .flag_z_we (flag_z_we),
  .flag_s_we (flag_s_we)
);

// File: tb/sim_xlc_unit.sv
module sim_xlc_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd6;
  logic [31:0] operand = '0;
  logic [31:0] result;
  logic        res_we, dst_r0, flag_z, flag_s, flag_z_we, flag_s_we;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xlc_unit u0 (
    .op_sel(op_sel), .operand(operand), .result(result), .res_we(res_we),
    .dst_r0(dst_r0), .flag_z(flag_z), .flag_s(flag_s),
    .flag_z_we(flag_z_we), .flag_s_we(flag_s_we)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d opnd=%h actual=%h expected=%h",
               tag, what, op_sel, operand, act, exp);
    end
  endtask

  task automatic apply(input int o, input logic [31:0] v);
    longint      r;
    int          n;
    bit          tgt;
    bit          valid, to_r0;
    string       tag;
    @(posedge clk);
    op_sel  = 3'(o);
    operand = v;
    r = 0; valid = 1'b1; to_r0 = 1'b0;
    case (o)
      0: begin tag = "R1"; r = v % 256;   if (r >= 128)   r = r - 256;   end
      1: begin tag = "R2"; r = v % 65536; if (r >= 32768) r = r - 65536; end
      2: begin tag = "R3"; r = v % 256;   end
      3: begin tag = "R4"; r = v % 65536; end
      4, 5: begin
        tag = (o == 4) ? "R5" : "R6";
        tgt = (o == 5);
        n = 0;
        while (n < 32 && v[31-n] == tgt) n++;
        r = n; to_r0 = 1'b1;
      end
      default: begin tag = "R10"; valid = 1'b0; end
    endcase
    @(negedge clk);
    check(tag, "result", result, 32'(r));
    if (valid) begin
      check("R7", "res_we", {31'd0, res_we}, 32'd1);
      check("R7", "dst_r0", {31'd0, dst_r0}, {31'd0, to_r0});
      if (to_r0) begin
        check("R9", "z_we/s_we", {30'd0, flag_z_we, flag_s_we}, 32'd2);
        check("R9", "flag_z", {31'd0, flag_z}, {31'd0, (r == 0)});
      end else begin
        check("R8", "z_we/s_we", {30'd0, flag_z_we, flag_s_we}, 32'd3);
        check("R8", "flag_z", {31'd0, flag_z}, {31'd0, (32'(r) == 0)});
        check("R8", "flag_s", {31'd0, flag_s}, {31'd0, r < 0});
      end
    end else begin
      check("R10", "writes", {28'd0, res_we, dst_r0, flag_z_we, flag_s_we}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] edges [12];
    edges = '{32'h0, 32'hFFFFFFFF, 32'h80, 32'h7F, 32'h8000, 32'h7FFF,
              32'h1, 32'h80000000, 32'h7FFFFFFF, 32'h0000FF00,
              32'hFFFF0000, 32'h00008080};
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: unused code idles the unit (R10)
    check("R10", "idle writes", {28'd0, res_we, dst_r0, flag_z_we, flag_s_we}, 32'd0);
    for (int o = 0; o < 8; o++)
      for (int e = 0; e < 12; e++) apply(o, edges[e]);
    // single set bit at every position: counts 0..31 (R5, R6)
    for (int b = 0; b < 32; b++) begin
      apply(4, 32'h1 << b);
      apply(5, ~(32'h1 << b));
    end
    seed = 32'h1234ABCD;
    for (int k = 0; k < 400; k++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      apply(k % 8, seed >> (k % 29));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule